// File: doc/BRIEF.md
# Line Clamp Pulse Timing Generator

This block produces one clamp enable pulse per video line for an AC-coupled analog front end. It watches a horizontal sync input, finds the edge that ends each sync pulse, waits a programmed number of pixel clocks, and then holds the clamp enable high for a programmed number of pixel clocks. If the start offset is small, the pulse lands on the back porch. If it is large enough to step over the active picture, the pulse lands on the front porch of the same line.

Two controls can stop the pulse. While the recovered pixel clock loop is coasting and the coast-inhibit control is at its default of 0, the pulse for that line is dropped. When DC coupling is selected, no clamp is issued at all. The start offset and the width are loaded through a small parallel write port. The sync polarity, coupling mode and coast control are static pins.

Top module: `line_clamp_gen`

## Requirements
- R1: Reset is asynchronous and active low. While `rst_n` is low, `clamp_out` is 0 at once, without waiting for a clock edge. Reset clears the start offset to 0 and the width to 0, so the first line after reset produces no pulse.
- R2: The trailing sync edge is counted from the first rising clock edge after it appears at `hsync_in`. `clamp_out` goes high on the (start+4)th rising clock edge after that edge. This count includes the two-flop synchronizer, edge detection and the registered output.
- R3: `clamp_out` stays high for exactly `width` clock cycles. A width of 0 produces no pulse.
- R4: The start offset is 12 bits wide. Writing address 0 loads bits 7:0 from `reg_wdata`. Writing address 1 loads bits 11:8 from `reg_wdata[3:0]`. Address 2 loads the 8-bit width. Offsets up to 4095 are counted in full, without wrapping.
- R5: When `hsync_active_low` is 0, sync is active high and a falling edge of `hsync_in` is the trailing edge. When it is 1, a rising edge is the trailing edge.
- R6: A trailing edge that arrives while the block is counting the offset or driving the pulse has the following effect:
  - the current pulse ends;
  - the offset count starts again from the new edge.
- R7: `pll_coast` is sampled only when the offset count expires. If it is 1 at that point and `coast_clamp_en` is 0, the whole pulse for that line is skipped. If `coast_clamp_en` is 1, coasting has no effect. Coast that starts after the pulse has begun does not shorten the pulse.
- R8: While `dc_couple` is 1, `clamp_out` is 0 from the next clock edge on, and trailing edges are ignored. With `dc_couple` at 0, pulses are produced normally.
- R9: Every trailing edge produces exactly one pulse. Successive lines each give one pulse of the programmed width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous to clk |
| hsync_active_low | input | 1 | 1: sync is active low; 0: sync is active high |
| pll_coast | input | 1 | Clock recovery loop is coasting |
| dc_couple | input | 1 | 1: DC-coupled, clamp disabled; 0: AC-coupled |
| coast_clamp_en | input | 1 | 1: clamp is also issued during coast |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0: offset low, 1: offset high, 2: width |
| reg_wdata | input | 8 | Register write data |
| clamp_out | output | 1 | Registered clamp enable |

## Verification
The assertions check the following on every cycle:
- the DC-mode shutoff;
- the coast decision, at each cycle where a pulse starts;
- that a zero width never starts a pulse;
- that a detected trailing edge always drops the clamp on the next cycle;
- that the clamp is low whenever reset is held.

Only the bench scenarios can show the exact start latency and the pulse length for each offset, width and polarity. The same holds for front-porch placement with the largest offset, restart on a second edge, the once-per-line behaviour, and coast that arrives after a pulse has begun.

// File: rtl/line_clamp_gen.sv
module line_clamp_gen #(
  parameter int DATA_W  = 8,
  parameter int START_W = 12,
  parameter int WIDTH_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_in,
  input  logic              hsync_active_low,
  input  logic              pll_coast,
  input  logic              dc_couple,
  input  logic              coast_clamp_en,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              clamp_out
);
  localparam int HI_W = START_W - DATA_W;

  typedef enum logic [1:0] {IDLE, COUNT, CLAMP} state_t;

  logic [DATA_W-1:0]  start_lo;
  logic [HI_W-1:0]    start_hi;
  logic [WIDTH_W-1:0] width_q;
  logic [2:0]         sy;
  logic [START_W-1:0] cnt;
  logic [WIDTH_W-1:0] wcnt;
  state_t             state;

  wire [START_W-1:0] start_val   = {start_hi, start_lo};
  wire               hs_now      = sy[1] ^ hsync_active_low;
  wire               hs_prev     = sy[2] ^ hsync_active_low;
  wire               trail       = hs_prev & ~hs_now;
  wire               expire      = (state == COUNT) && (cnt == start_val);
  wire               coast_block = pll_coast & ~coast_clamp_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_lo <= '0;
      start_hi <= '0;
      width_q  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        2'd0:    start_lo <= reg_wdata;
        2'd1:    start_hi <= reg_wdata[HI_W-1:0];
        2'd2:    width_q  <= reg_wdata[WIDTH_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], hsync_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      cnt       <= '0;
      wcnt      <= '0;
      clamp_out <= 1'b0;
    end else if (dc_couple) begin
      state     <= IDLE;
      clamp_out <= 1'b0;
    end else if (trail) begin
      state     <= COUNT;
      cnt       <= '0;
      clamp_out <= 1'b0;
    end else begin
      case (state)
        COUNT: begin
          if (expire) begin
            if (width_q == '0 || coast_block) begin
              state <= IDLE;
            end else begin
              state     <= CLAMP;
              clamp_out <= 1'b1;
              wcnt      <= WIDTH_W'(1);
            end
          end else begin
            cnt <= cnt + START_W'(1);
          end
        end
        CLAMP: begin
          if (wcnt >= width_q) begin
            state     <= IDLE;
            clamp_out <= 1'b0;
          end else begin
            wcnt <= wcnt + WIDTH_W'(1);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module line_clamp_chk #(
  parameter int WIDTH_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dc_couple,
  input logic               pll_coast,
  input logic               coast_clamp_en,
  input logic               trail,
  input logic [WIDTH_W-1:0] width_q,
  input logic               clamp_out
);
  always @(posedge clk) begin
    if (!rst_n) a_r1_reset_low: assert (!clamp_out);
  end

  a_r8_dc_never: assert property (@(posedge clk) disable iff (!rst_n)
    dc_couple |=> !clamp_out);

  a_r7_coast_skip: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_out) |-> $past(!pll_coast || coast_clamp_en));

  a_r3_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_out) |-> $past(width_q != '0));

  a_r6_retrigger_abort: assert property (@(posedge clk) disable iff (!rst_n)
    trail |=> !clamp_out);
endmodule

bind line_clamp_gen line_clamp_chk #(.WIDTH_W(WIDTH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dc_couple(dc_couple), .pll_coast(pll_coast),
  .coast_clamp_en(coast_clamp_en), .trail(trail), .width_q(width_q),
  .clamp_out(clamp_out)
);

// File: tb/sim_line_clamp_gen.sv
`timescale 1ns/1ps
module sim_line_clamp_gen;
  logic clk = 0, rst_n = 0, hsync_in = 0, pol = 0, coast = 0, dc = 0, cen = 0;
  logic we = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic clamp;

  line_clamp_gen u0 (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .hsync_active_low(pol),
    .pll_coast(coast), .dc_couple(dc), .coast_clamp_en(cen), .reg_we(we),
    .reg_addr(addr), .reg_wdata(wdata), .clamp_out(clamp)
  );

  always #2.5 clk = ~clk;

  int cyc = 0, checks = 0, failures = 0;
  int rises = 0, hi_cnt = 0, rise_cyc = 0, t0 = 0;
  logic prev = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (clamp) hi_cnt = hi_cnt + 1;
    if (clamp && !prev) begin rises = rises + 1; rise_cyc = cyc; end
    prev = clamp;
  end

  localparam int NV = 8;
  localparam int V_POL  [NV] = '{0, 1, 0, 0, 0, 0, 1, 1};
  localparam int V_START[NV] = '{3, 0, 266, 10, 10, 10, 4095, 20};
  localparam int V_WIDTH[NV] = '{4, 1, 7, 0, 5, 5, 255, 200};
  localparam int V_CEN  [NV] = '{0, 0, 0, 0, 0, 1, 0, 0};
  localparam int V_COAST[NV] = '{0, 0, 0, 0, 1, 1, 0, 0};
  localparam int V_LEN  [NV] = '{4, 1, 7, 0, 0, 5, 255, 200};

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1; addr = a; wdata = d;
    tick(1);
    we = 0;
  endtask

  task automatic setup(input int start, input int width);
    wr(2'd0, 8'(start));
    wr(2'd1, 8'(start >> 8));
    wr(2'd2, 8'(width));
  endtask

  task automatic clear_mon();
    tick(1);
    rises = 0; hi_cnt = 0; rise_cyc = 0;
  endtask

  task automatic drive_trail();
    hsync_in = ~pol;
    tick(4);
    hsync_in = pol;
    t0 = cyc;
  endtask

  initial begin
    #750000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    chk(clamp == 0, "R1 clamp low in reset", clamp, 0);
    rst_n = 1;
    tick(3);
    clear_mon();
    drive_trail();
    tick(40);
    chk(rises == 0, "R1 reset width 0 gives no pulse", rises, 0);

    for (int i = 0; i < NV; i++) begin
      wr(2'd2, 8'd0);
      pol = V_POL[i][0];
      hsync_in = pol;
      cen = V_CEN[i][0];
      coast = V_COAST[i][0];
      tick(8);
      setup(V_START[i], V_WIDTH[i]);
      clear_mon();
      drive_trail();
      tick(V_START[i] + V_WIDTH[i] + 20);
      chk(rises == (V_LEN[i] > 0 ? 1 : 0), "R9 R7 pulse count", rises, V_LEN[i] > 0 ? 1 : 0);
      chk(hi_cnt == V_LEN[i], "R3 R7 pulse width", hi_cnt, V_LEN[i]);
      if (V_LEN[i] > 0)
        chk(rise_cyc - t0 == V_START[i] + 4, "R2 R4 R5 start latency", rise_cyc - t0, V_START[i] + 4);
      coast = 0;
      cen = 0;
    end

    wr(2'd2, 8'd0);
    pol = 0; hsync_in = 0;
    tick(8);
    setup(5, 3);
    clear_mon();
    for (int k = 0; k < 3; k++) begin
      drive_trail();
      tick(30);
    end
    chk(rises == 3, "R9 one pulse per line", rises, 3);
    chk(hi_cnt == 9, "R9 width per line", hi_cnt, 9);

    setup(5, 20);
    clear_mon();
    drive_trail();
    tick(12);
    coast = 1;
    tick(30);
    coast = 0;
    chk(hi_cnt == 20, "R7 late coast keeps pulse", hi_cnt, 20);

    setup(20, 10);
    clear_mon();
    drive_trail();
    tick(8);
    hsync_in = 1;
    tick(4);
    hsync_in = 0;
    t0 = cyc;
    tick(50);
    chk(rises == 1, "R6 restart during count", rises, 1);
    chk(rise_cyc - t0 == 24, "R6 restart latency", rise_cyc - t0, 24);
    chk(hi_cnt == 10, "R6 restart width", hi_cnt, 10);

    setup(5, 30);
    clear_mon();
    drive_trail();
    tick(15);
    hsync_in = 1;
    tick(2);
    hsync_in = 0;
    t0 = cyc;
    tick(50);
    chk(rises == 2, "R6 abort during clamp count", rises, 2);
    chk(hi_cnt == 41, "R6 abort truncates pulse", hi_cnt, 41);
    chk(rise_cyc - t0 == 9, "R6 restart after abort", rise_cyc - t0, 9);

    setup(5, 5);
    dc = 1;
    clear_mon();
    drive_trail();
    tick(40);
    chk(rises == 0, "R8 dc mode no clamp", rises, 0);
    dc = 0;
    tick(2);
    clear_mon();
    drive_trail();
    tick(30);
    chk(hi_cnt == 5, "R8 ac mode clamps again", hi_cnt, 5);

    setup(2, 50);
    clear_mon();
    drive_trail();
    tick(10);
    chk(clamp == 1, "R9 pulse active before reset", clamp, 1);
    rst_n = 0;
    #1;
    chk(clamp == 0, "R1 async reset drops clamp", clamp, 0);
    tick(2);
    rst_n = 1;
    tick(2);
    clear_mon();
    drive_trail();
    tick(30);
    chk(rises == 0, "R1 registers cleared by reset", rises, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule